// File: doc/BRIEF.md
# Delayed Memory Bridge with Response Reservation

The bridge sits between an upstream requester and a downstream memory. Requests that are admitted go into a bounded request queue and are forwarded only after a fixed number of cycles. Responses coming back from the memory go through their own bounded queue and are held for the same number of cycles before they go upstream. Every queued entry carries a timestamp taken from a free-running cycle counter, so each packet is released on its own schedule. A busy neighbour never costs a packet: the head entry stays presented until the neighbour takes it.

When a request that will produce a response is admitted, the bridge claims a response-queue slot for it at that moment. A request is therefore refused when no slot is left, and a response that comes back always finds room. A request whose response is handled by another agent, or a request that needs no answer, claims nothing. Refusal is signalled by dropping the upstream ready. The requester keeps the request stable and offers it again.

Top module: `delay_bridge`

## Requirements
- R1: After reset both output valids (`dnValid`, `upRspValid`) are low, `rspInReady` is high and `upReady` is high for any request kind.
- R2: Once REQ_DEPTH requests are queued and none has left, `upReady` is low even for a request that needs no response.
- R3: A request with `upNeedRsp`=1 and `upSuppress`=0 is refused (`upReady` low) while RSP_DEPTH reservations are outstanding.
- R4: A request with `upNeedRsp`=0 or `upSuppress`=1 reserves nothing and is not refused for lack of reservations. It is forwarded with `dnExpectRsp` = `upNeedRsp` AND NOT `upSuppress`.
- R5: A request accepted in cycle k gives `dnValid` no earlier than cycle k+DELAY. It gives `dnValid` in every cycle from then on while it is at the head of the queue.
- R6: A response accepted on `rspIn` in cycle j gives `upRspValid` no earlier than cycle j+DELAY, and from then on while at the head. A stalled output holds its data.
- R7: Requests leave in acceptance order with unchanged address and data. Responses leave in arrival order. Nothing is duplicated or dropped.
- R8: While `dnReady` is low, `dnValid` stays high and `dnAddr`/`dnData`/`dnExpectRsp` stay stable. The packet goes out in the first cycle `dnReady` is high.
- R9: A reservation is returned when its response is taken upstream, so the outstanding count never exceeds RSP_DEPTH. A response that arrives for a reservation always sees `rspInReady` high, even while `upRspReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| upValid | input | 1 | Upstream request valid |
| upReady | output | 1 | Request admitted this cycle if valid |
| upAddr | input | ADDR_W | Request address |
| upData | input | DATA_W | Request write data |
| upNeedRsp | input | 1 | Request expects a response |
| upSuppress | input | 1 | Response will be supplied by another agent |
| dnValid | output | 1 | Released request presented downstream |
| dnReady | input | 1 | Downstream accepts request |
| dnAddr | output | ADDR_W | Forwarded address |
| dnData | output | DATA_W | Forwarded data |
| dnExpectRsp | output | 1 | Downstream must answer this request |
| rspInValid | input | 1 | Response from downstream valid |
| rspInReady | output | 1 | Response queue has room |
| rspInData | input | DATA_W | Response data from downstream |
| upRspValid | output | 1 | Released response presented upstream |
| upRspReady | input | 1 | Requester accepts response |
| upRspData | output | DATA_W | Response data to requester |

## Verification
The bench first fills the request queue against a stalled memory. A design that counted depth wrongly would accept a fifth request and lose it, or would refuse too early. It then uses every reservation without returning responses, and probes with both answering and non-answering requests. A design that reserved on arrival of the response, or that charged suppressed requests, would show the wrong `upReady`. Responses are then returned while the requester stalls, and a design without reservations would drop one or drop `rspInReady`. A long run with random back-pressure follows. The 8-bit timestamp counter wraps many times during that run, and every cycle the bench compares each output against its exact release cycle and its expected order. A wrap bug or an off-by-one in the delay therefore shows up as an early or a missing valid.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef struct packed {
    logic reqPush;
    logic reqExpect;
    logic reqPop;
    logic rspPush;
    logic rspPop;
  } bridge_strobe_t;
endpackage

// File: rtl/bridge_fifo.sv
module bridge_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int TS_W = 16,
  parameter int unsigned DELAY = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  input  logic [TS_W-1:0]  now,
  output logic             full,
  output logic             headReady,
  output logic [WIDTH-1:0] headData
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [TS_W-1:0] WAIT = TS_W'(DELAY);

  logic [WIDTH-1:0] dataMem [DEPTH];
  logic [TS_W-1:0]  stampMem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic [TS_W-1:0]  age;

  always_ff @(posedge clk) begin
    if (push) begin
      dataMem[wrPtr]  <= pushData;
      stampMem[wrPtr] <= now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // modular difference stays correct across counter wrap
  assign age       = now - stampMem[rdPtr];
  assign headReady = (count != '0) && (age >= WAIT);
  assign headData  = dataMem[rdPtr];
  assign full      = (count == CNT_W'(DEPTH));

  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> count != '0);
  p_push_room_r2: assert property (@(posedge clk) disable iff (!rstN)
    push |-> count < CNT_W'(DEPTH));
endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int REQ_DEPTH = 16,
  parameter int RSP_DEPTH = 16,
  parameter int TS_W = 32,
  parameter int unsigned DELAY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridge_strobe_t    strobe,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [DATA_W-1:0] upData,
  input  logic [DATA_W-1:0] rspInData,
  output logic              dnValid,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [DATA_W-1:0] dnData,
  output logic              dnExpectRsp,
  output logic              upRspValid,
  output logic [DATA_W-1:0] upRspData,
  output logic              reqFull,
  output logic              rspFull
);
  localparam int REQ_W = ADDR_W + DATA_W + 1;

  logic [TS_W-1:0]  now;
  logic [REQ_W-1:0] reqHead;

  always_ff @(posedge clk) begin
    if (!rstN) now <= '0;
    else       now <= now + 1'b1;
  end

  bridge_fifo #(.WIDTH(REQ_W), .DEPTH(REQ_DEPTH), .TS_W(TS_W), .DELAY(DELAY)) i_reqq (
    .clk(clk), .rstN(rstN),
    .push(strobe.reqPush), .pushData({strobe.reqExpect, upData, upAddr}),
    .pop(strobe.reqPop), .now(now),
    .full(reqFull), .headReady(dnValid), .headData(reqHead)
  );

  bridge_fifo #(.WIDTH(DATA_W), .DEPTH(RSP_DEPTH), .TS_W(TS_W), .DELAY(DELAY)) i_rspq (
    .clk(clk), .rstN(rstN),
    .push(strobe.rspPush), .pushData(rspInData),
    .pop(strobe.rspPop), .now(now),
    .full(rspFull), .headReady(upRspValid), .headData(upRspData)
  );

  assign {dnExpectRsp, dnData, dnAddr} = reqHead;

  p_dn_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    dnValid && !strobe.reqPop |=> dnValid && $stable(reqHead));
  p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    upRspValid && !strobe.rspPop |=> upRspValid && $stable(upRspData));
endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int RSP_DEPTH = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           upValid,
  input  logic           upNeedRsp,
  input  logic           upSuppress,
  input  logic           dnReady,
  input  logic           rspInValid,
  input  logic           upRspReady,
  input  logic           dnValid,
  input  logic           upRspValid,
  input  logic           reqFull,
  input  logic           rspFull,
  output logic           upReady,
  output logic           rspInReady,
  output bridge_strobe_t strobe
);
  localparam int OUT_W = $clog2(RSP_DEPTH + 1);
  localparam logic [OUT_W-1:0] LIMIT = OUT_W'(RSP_DEPTH);

  logic [OUT_W-1:0] outstanding;
  logic expects, resvOk;

  assign expects    = upNeedRsp && !upSuppress;
  assign resvOk     = outstanding < LIMIT;
  assign upReady    = !reqFull && (!expects || resvOk);
  assign rspInReady = !rspFull;

  always_comb begin
    strobe.reqPush   = upValid && upReady;
    strobe.reqExpect = expects;
    strobe.reqPop    = dnValid && dnReady;
    strobe.rspPush   = rspInValid && rspInReady;
    strobe.rspPop    = upRspValid && upRspReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= '0;
    end else begin
      case ({strobe.reqPush && expects, strobe.rspPop})
        2'b10:   outstanding <= outstanding + 1'b1;
        2'b01:   outstanding <= outstanding - 1'b1;
        default: outstanding <= outstanding;
      endcase
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    outstanding <= LIMIT);
  p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqFull |-> !upReady);
  p_rsp_room_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspInValid |-> rspInReady);
  p_rsp_reserved_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rspPop |-> outstanding != '0);
endmodule

// File: rtl/delay_bridge.sv
module delay_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int REQ_DEPTH = 16,
  parameter int RSP_DEPTH = 16,
  parameter int TS_W = 32,
  parameter int unsigned DELAY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upValid,
  output logic              upReady,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [DATA_W-1:0] upData,
  input  logic              upNeedRsp,
  input  logic              upSuppress,
  output logic              dnValid,
  input  logic              dnReady,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [DATA_W-1:0] dnData,
  output logic              dnExpectRsp,
  input  logic              rspInValid,
  output logic              rspInReady,
  input  logic [DATA_W-1:0] rspInData,
  output logic              upRspValid,
  input  logic              upRspReady,
  output logic [DATA_W-1:0] upRspData
);
  bridge_strobe_t strobe;
  logic reqFull, rspFull;

  bridge_ctrl #(.RSP_DEPTH(RSP_DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .upValid(upValid), .upNeedRsp(upNeedRsp), .upSuppress(upSuppress),
    .dnReady(dnReady), .rspInValid(rspInValid), .upRspReady(upRspReady),
    .dnValid(dnValid), .upRspValid(upRspValid),
    .reqFull(reqFull), .rspFull(rspFull),
    .upReady(upReady), .rspInReady(rspInReady), .strobe(strobe)
  );

  bridge_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_DEPTH(REQ_DEPTH),
    .RSP_DEPTH(RSP_DEPTH), .TS_W(TS_W), .DELAY(DELAY)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .upAddr(upAddr), .upData(upData), .rspInData(rspInData),
    .dnValid(dnValid), .dnAddr(dnAddr), .dnData(dnData), .dnExpectRsp(dnExpectRsp),
    .upRspValid(upRspValid), .upRspData(upRspData),
    .reqFull(reqFull), .rspFull(rspFull)
  );
endmodule

// File: tb/test_delay_bridge.sv
`timescale 1ns/1ps
module test_delay_bridge;
  localparam int REQ_DEPTH = 4;
  localparam int RSP_DEPTH = 4;
  localparam int DELAY = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upValid = 1'b0, upNeedRsp = 1'b0, upSuppress = 1'b0;
  logic [15:0] upAddr = '0, upData = '0, rspInData = '0;
  logic dnReady = 1'b0, rspInValid = 1'b0, upRspReady = 1'b0;
  logic upReady, dnValid, dnExpectRsp, rspInReady, upRspValid;
  logic [15:0] dnAddr, dnData, upRspData;

  delay_bridge #(.ADDR_W(16), .DATA_W(16), .REQ_DEPTH(REQ_DEPTH), .RSP_DEPTH(RSP_DEPTH),
                 .TS_W(8), .DELAY(DELAY)) i_delay_bridge (
    .clk(clk), .rstN(rstN), .upValid(upValid), .upReady(upReady), .upAddr(upAddr),
    .upData(upData), .upNeedRsp(upNeedRsp), .upSuppress(upSuppress),
    .dnValid(dnValid), .dnReady(dnReady), .dnAddr(dnAddr), .dnData(dnData),
    .dnExpectRsp(dnExpectRsp), .rspInValid(rspInValid), .rspInReady(rspInReady),
    .rspInData(rspInData), .upRspValid(upRspValid), .upRspReady(upRspReady),
    .upRspData(upRspData)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int vecs = 0, errs = 0;
  int outst = 0;
  bit done = 0;
  bit randMode = 0, rspEn = 0, dnHold = 0, rspHold = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [15:0] reqAddrQ[$], reqDataQ[$], pendQ[$], rspDataQ[$];
  logic        reqExpQ[$];
  int          reqRelQ[$], rspRelQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  // environment: back-pressure and downstream responder
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dnReady    = randMode ? lfsr[1] : dnHold;
    upRspReady = randMode ? lfsr[3] : rspHold;
    if (rspEn && pendQ.size() > 0 && (!randMode || lfsr[5])) begin
      rspInValid = 1'b1;
      rspInData  = pendQ[0];
    end else begin
      rspInValid = 1'b0;
    end
  end

  // monitor and scoreboard
  always begin
    @(negedge clk); #2;
    if (rstN) begin
      if (reqAddrQ.size() > 0 && cyc >= reqRelQ[0])
        chk("R5 dnValid at release cycle", dnValid, 1);
      if (dnValid) begin
        if (reqAddrQ.size() == 0) chk("R7 unexpected dnValid", 1, 0);
        else begin
          chk("R5 request not early", cyc >= reqRelQ[0], 1);
          chk("R7 request address order", dnAddr, reqAddrQ[0]);
          chk("R7 request data", dnData, reqDataQ[0]);
          chk("R4 dnExpectRsp flag", dnExpectRsp, reqExpQ[0]);
          if (dnReady) begin
            if (dnExpectRsp) pendQ.push_back(dnAddr ^ 16'h5A5A);
            void'(reqAddrQ.pop_front()); void'(reqDataQ.pop_front());
            void'(reqExpQ.pop_front());  void'(reqRelQ.pop_front());
          end
        end
      end
      if (upValid && upReady) begin
        reqAddrQ.push_back(upAddr);
        reqDataQ.push_back(upData);
        reqExpQ.push_back(upNeedRsp && !upSuppress);
        reqRelQ.push_back(cyc + DELAY);
        if (upNeedRsp && !upSuppress) outst++;
        chk("R3 reservations within limit", outst <= RSP_DEPTH, 1);
      end
      if (rspInValid) begin
        chk("R9 response always has room", rspInReady, 1);
        if (rspInReady) begin
          rspDataQ.push_back(rspInData);
          rspRelQ.push_back(cyc + DELAY);
          void'(pendQ.pop_front());
        end
      end
      if (rspDataQ.size() > 0 && cyc >= rspRelQ[0])
        chk("R6 upRspValid at release cycle", upRspValid, 1);
      if (upRspValid) begin
        if (rspDataQ.size() == 0) chk("R7 unexpected upRspValid", 1, 0);
        else begin
          chk("R6 response not early", cyc >= rspRelQ[0], 1);
          chk("R7 response order", upRspData, rspDataQ[0]);
          if (upRspReady) begin
            void'(rspDataQ.pop_front()); void'(rspRelQ.pop_front());
            outst--;
          end
        end
      end
    end
  end

  // call just after a negedge; returns at a negedge with upValid low
  task automatic sendReq(input logic [15:0] a, input logic nr, input logic sp);
    upValid = 1'b1; upAddr = a; upData = a ^ 16'h0F0F; upNeedRsp = nr; upSuppress = sp;
    #1;
    while (!upReady) begin @(negedge clk); #1; end
    @(negedge clk);
    upValid = 1'b0; upNeedRsp = 1'b0; upSuppress = 1'b0;
  endtask

  task automatic probe(input logic nr, input logic sp, input logic exp, input string rq);
    upValid = 1'b1; upAddr = 16'hFFFF; upNeedRsp = nr; upSuppress = sp;
    #1;
    chk(rq, upReady, exp);
    upValid = 1'b0; upNeedRsp = 1'b0; upSuppress = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 dnValid after reset", dnValid, 0);
    chk("R1 upRspValid after reset", upRspValid, 0);
    chk("R1 rspInReady after reset", rspInReady, 1);
    chk("R1 upReady after reset", upReady, 1);
    @(negedge clk);
    probe(1, 0, 1, "R1 upReady for answering request after reset");

    // exact latency, idle neighbours
    dnHold = 1; rspHold = 1; rspEn = 1;
    @(negedge clk);
    sendReq(16'h0010, 1, 0);
    idle(3);
    sendReq(16'h0011, 0, 0);
    sendReq(16'h0012, 1, 1);
    sendReq(16'h0013, 1, 0);
    idle(15);

    // R2: fill request queue against stalled memory
    dnHold = 0;
    for (int i = 0; i < REQ_DEPTH; i++) sendReq(16'h0100 + 16'(i), 0, 0);
    probe(0, 0, 0, "R2 upReady low with request queue full");
    idle(6);
    probe(0, 0, 0, "R2 still full while downstream stalls");
    dnHold = 1;  // R8 release of stalled head
    idle(3 * REQ_DEPTH + 10);

    // R3/R4: exhaust reservations with responses withheld
    rspEn = 0;
    for (int i = 0; i < RSP_DEPTH; i++) sendReq(16'h0200 + 16'(i), 1, 0);
    idle(DELAY + 6);
    probe(1, 0, 0, "R3 refused with all reservations taken");
    probe(1, 1, 1, "R4 suppressed request not charged");
    probe(0, 0, 1, "R4 non-answering request admitted");
    sendReq(16'h0280, 0, 0);
    sendReq(16'h0281, 1, 1);
    idle(DELAY + 4);
    // R9: responses come back while requester stalls
    rspHold = 0; rspEn = 1;
    idle(20);
    probe(1, 0, 0, "R9 reservation held until response taken");
    rspHold = 1;
    idle(20);
    probe(1, 0, 1, "R9 reservation returned after response taken");

    // mixed traffic with random back-pressure
    randMode = 1;
    for (int i = 0; i < 400; i++)
      sendReq(16'h1000 + 16'(i), (i % 3) != 0, (i % 5) == 0);
    randMode = 0; dnHold = 1; rspHold = 1;
    idle(120);
    chk("R7 all requests delivered", reqAddrQ.size(), 0);
    chk("R7 all responses returned", pendQ.size() + rspDataQ.size(), 0);
    chk("R9 reservations all released", outst, 0);
    probe(1, 0, 1, "R9 full reservation pool available at end");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog expired (all requirements)");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule